// File: doc/BRIEF.md
# AT Legacy I/O Decoder and System Control Port

This block sits between a CPU I/O cycle and the classic AT peripherals of a chipset. Each cycle it takes a dword I/O address, four byte enables and separate read and write strobes. It resolves them to a single byte address. It then raises one registered chip select for the peripheral that owns that byte: the two DMA controllers, the two interrupt controllers, the interval timer, the keyboard data, status or command port, the real-time clock, or the DMA page registers. Along with the select it gives the register offset inside the selected range. The peripherals themselves live elsewhere.

Two small pieces of state are kept inside the block. The first is the system control port at byte 0x61: a write-only latch that drives the speaker gate and speaker data lines, which reads back merged with a free-running refresh toggle and the live timer channel 2 output. The second is the NMI-enable flag, loaded by writes to the RTC index byte.

Top module: `at_sysport_decoder`

## Requirements
- R1: A single-byte access in byte range 0x00-0x1F raises `sel[0]` (DMA 1), 0x20-0x3F raises `sel[1]` (master interrupt controller), 0x40-0x5F raises `sel[2]` (timer), 0x80-0x9F raises `sel[7]` (page registers), 0xA0-0xBF raises `sel[8]` (slave interrupt controller) and 0xC0-0xDF raises `sel[9]` (DMA 2). At most one bit of `sel` is ever high.
- R2: Byte 0x60 raises `sel[3]` (keyboard data). Byte 0x61 is the system control port and raises no select. Bytes 0x62, 0x63, 0x68-0x6F and 0xE0-0xFF raise nothing.
- R3: Bytes 0x64-0x67 raise `sel[4]` (keyboard status) on a read and `sel[5]` (keyboard command) on a write. Bytes 0x70-0x7F raise `sel[6]` (RTC).
- R4: `reg_idx` is the byte offset from the base of the selected range. The bases are 0x00/0x20/0x40/0x80/0xA0 for the wide ranges, 0x60 for keyboard data, 0x64 for status/command and 0x70 for the RTC. For DMA 2 (base 0xC0) the offset is halved. `reg_idx` is 0 when nothing is selected.
- R5: The byte address is `{io_dw_addr[7:2], lane}`, where lane is the position of the single set bit of `io_be`. An access with zero or several byte enables, or with any `io_dw_addr` bit above bit 7 set, selects nothing. A cycle with neither strobe, or with both strobes, is idle: no select and `rdata` = 0x00.
- R6: A read that selects nothing and is not byte 0x61 returns `rdata` = 0xFF. A read that raises a select returns 0x00.
- R7: `sel`, `reg_idx` and `rdata` are registered and reflect the access presented one clock earlier.
- R8: A write to byte 0x61 stores data bits 3:0 in the control latch, taking the byte from the lane of the access. `spk_gate` follows latch bit 0 and `spk_data` follows latch bit 1.
- R9: A read of byte 0x61 returns `{2'b00, t2_out, refresh_tgl, latch[3:0]}`. Bits 7 and 6 are always 0, and bits 5 and 4 are the live timer and refresh values at the access.
- R10: `refresh_tgl` is 0 after reset and inverts once every TOGGLE_CYCLES clocks, where TOGGLE_CYCLES = CLK_KHZ*REFRESH_NS/1e6 (754 at the 50 MHz default).
- R11: A write to byte 0x70 loads `nmi_en` from data bit 7 of lane 0. Reads of 0x70 and writes to other RTC bytes leave `nmi_en` unchanged.
- R12: Synchronous reset clears `sel`, `reg_idx`, `rdata`, the control latch, `nmi_en` and `refresh_tgl`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_dw_addr | input | IO_AW-2 | Dword I/O address (byte address bits IO_AW-1:2) |
| io_be | input | 4 | Byte enables, one per lane |
| io_rd | input | 1 | Read strobe |
| io_wr | input | 1 | Write strobe |
| io_wdata | input | 32 | Write data, byte lanes 0..3 |
| t2_out | input | 1 | Timer channel 2 output |
| sel | output | 10 | One-hot peripheral selects, registered |
| reg_idx | output | 5 | Register offset in selected range, registered |
| rdata | output | 8 | Control port readback, 0xFF on unmapped read, registered |
| spk_gate | output | 1 | Speaker gate from control latch bit 0 |
| spk_data | output | 1 | Speaker data from control latch bit 1 |
| nmi_en | output | 1 | NMI enable flag |
| refresh_tgl | output | 1 | Refresh toggle |

## Verification
The bench sweeps every byte of the 256-byte space, each as a read and as a write, and compares the select, offset and read data against an arithmetic model. That sweep catches a boundary that is off by one, a range that swaps read and write, a halving error on DMA 2, and a missing 0xFF on the holes at 0x62, 0x68-0x6F and 0xE0-0xFF. Further cases go after multi-lane and empty byte enables, out-of-range upper address bits, and both strobes together. A design that ignored any of these would raise a select where none belongs. Control port readback is tried with bits 7:4 written as ones and with the timer input at both levels, which exposes an unmasked bit or a wrong splice position. The NMI flag is probed with a neighbouring RTC write and with a read of 0x70, which a decoder that is too loose would let corrupt it. The refresh period is also measured between two toggles.

// File: rtl/at_sysport_pkg.sv
package at_sysport_pkg;
  localparam int SEL_N     = 10;
  localparam int SEL_DMA1  = 0;
  localparam int SEL_PICM  = 1;
  localparam int SEL_PIT   = 2;
  localparam int SEL_KDATA = 3;
  localparam int SEL_KSTAT = 4;
  localparam int SEL_KCMD  = 5;
  localparam int SEL_RTC   = 6;
  localparam int SEL_PAGE  = 7;
  localparam int SEL_PICS  = 8;
  localparam int SEL_DMA2  = 9;

  localparam int IDX_W     = 5;
  localparam int LATCH_W   = 4;

  localparam logic [7:0] CTRL_PORT_BYTE = 8'h61;
  localparam logic [7:0] RTC_INDEX_BYTE = 8'h70;
  localparam logic [7:0] FLOAT_DATA     = 8'hFF;
endpackage

// File: rtl/at_io_range_decode.sv
module at_io_range_decode
  import at_sysport_pkg::*;
#(
  parameter int IO_AW = 16
) (
  input  logic [IO_AW-1:2]   dw_addr,
  input  logic [3:0]         be,
  input  logic               rd,
  input  logic               wr,
  output logic [SEL_N-1:0]   sel_n,
  output logic [IDX_W-1:0]   idx_n,
  output logic [1:0]         lane,
  output logic               ctrl_hit,
  output logic               rtc_index_wr
);
  logic       one_lane;
  logic       upper_zero;
  logic       valid;
  logic [7:0] byte_a;

  assign one_lane   = (be != 4'b0000) && ((be & (be - 4'd1)) == 4'b0000);
  assign upper_zero = (dw_addr[IO_AW-1:8] == '0);
  assign valid      = (rd ^ wr) && one_lane && upper_zero;

  always_comb begin
    lane = 2'd0;
    for (int i = 3; i >= 0; i--) begin
      if (be[i]) lane = 2'(i);
    end
  end

  assign byte_a = {dw_addr[7:2], lane};

  always_comb begin
    sel_n    = '0;
    idx_n    = '0;
    ctrl_hit = 1'b0;
    if (valid) begin
      unique case (byte_a[7:5])
        3'd0: begin sel_n[SEL_DMA1] = 1'b1; idx_n = byte_a[4:0]; end
        3'd1: begin sel_n[SEL_PICM] = 1'b1; idx_n = byte_a[4:0]; end
        3'd2: begin sel_n[SEL_PIT]  = 1'b1; idx_n = byte_a[4:0]; end
        3'd3: begin
          if (byte_a[4]) begin
            sel_n[SEL_RTC] = 1'b1;
            idx_n          = {1'b0, byte_a[3:0]};
          end else if (byte_a[3:2] == 2'b00) begin
            if (byte_a[1:0] == 2'd0) sel_n[SEL_KDATA] = 1'b1;
            else if (byte_a[1:0] == 2'd1) ctrl_hit = 1'b1;
          end else if (byte_a[3:2] == 2'b01) begin
            if (rd) sel_n[SEL_KSTAT] = 1'b1;
            else    sel_n[SEL_KCMD]  = 1'b1;
            idx_n = {3'b000, byte_a[1:0]};
          end
        end
        3'd4: begin sel_n[SEL_PAGE] = 1'b1; idx_n = byte_a[4:0]; end
        3'd5: begin sel_n[SEL_PICS] = 1'b1; idx_n = byte_a[4:0]; end
        3'd6: begin sel_n[SEL_DMA2] = 1'b1; idx_n = {1'b0, byte_a[4:1]}; end
        default: ;
      endcase
    end
  end

  assign rtc_index_wr = valid && wr && (byte_a == RTC_INDEX_BYTE);
endmodule

// File: rtl/at_refresh_timer.sv
module at_refresh_timer #(
  parameter int CLK_KHZ    = 50000,
  parameter int REFRESH_NS = 15085
) (
  input  logic clk,
  input  logic rst,
  output logic tgl
);
  localparam int RAW_CYCLES    = (CLK_KHZ * REFRESH_NS) / 1000000;
  localparam int TOGGLE_CYCLES = (RAW_CYCLES < 2) ? 2 : RAW_CYCLES;
  localparam int CNT_W         = $clog2(TOGGLE_CYCLES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TOGGLE_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      tgl <= 1'b0;
    end else if (cnt == LAST) begin
      cnt <= '0;
      tgl <= ~tgl;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R10: toggle only moves on the terminal count
  p_tgl_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (cnt != LAST) |=> $stable(tgl));
  p_cnt_bound_r10: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
endmodule

// File: rtl/at_ctrl_port.sv
module at_ctrl_port
  import at_sysport_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         latch_wr,
  input  logic [7:0]   wbyte,
  input  logic         nmi_load,
  input  logic         refresh,
  input  logic         t2,
  output logic [LATCH_W-1:0] latch,
  output logic         nmi_en,
  output logic [7:0]   rb_value
);
  logic unused_wbits;
  assign unused_wbits = ^wbyte[6:LATCH_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      latch  <= '0;
      nmi_en <= 1'b0;
    end else begin
      if (latch_wr) latch  <= wbyte[LATCH_W-1:0];
      if (nmi_load) nmi_en <= wbyte[7];
    end
  end

  assign rb_value = {2'b00, t2, refresh, latch};

  // R8: latch only changes on a control-port write
  p_latch_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !latch_wr |=> $stable(latch));
  // R11: NMI flag only changes on an RTC index write
  p_nmi_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !nmi_load |=> $stable(nmi_en));
endmodule

// File: rtl/at_sysport_decoder.sv
module at_sysport_decoder
  import at_sysport_pkg::*;
#(
  parameter int IO_AW      = 16,
  parameter int CLK_KHZ    = 50000,
  parameter int REFRESH_NS = 15085
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [IO_AW-1:2]   io_dw_addr,
  input  logic [3:0]         io_be,
  input  logic               io_rd,
  input  logic               io_wr,
  input  logic [31:0]        io_wdata,
  input  logic               t2_out,
  output logic [SEL_N-1:0]   sel,
  output logic [IDX_W-1:0]   reg_idx,
  output logic [7:0]         rdata,
  output logic               spk_gate,
  output logic               spk_data,
  output logic               nmi_en,
  output logic               refresh_tgl
);
  localparam int LANES = 4;

  logic [SEL_N-1:0]   sel_n;
  logic [IDX_W-1:0]   idx_n;
  logic [1:0]         lane;
  logic               ctrl_hit;
  logic               rtc_index_wr;
  logic [7:0]         lane_bytes [LANES];
  logic [7:0]         wbyte;
  logic [LATCH_W-1:0] latch;
  logic [7:0]         rb_value;
  logic               rd_only;
  logic [7:0]         rdata_n;

  at_io_range_decode #(.IO_AW(IO_AW)) u_dec (
    .dw_addr      (io_dw_addr),
    .be           (io_be),
    .rd           (io_rd),
    .wr           (io_wr),
    .sel_n        (sel_n),
    .idx_n        (idx_n),
    .lane         (lane),
    .ctrl_hit     (ctrl_hit),
    .rtc_index_wr (rtc_index_wr)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_bytes[g] = io_wdata[8*g +: 8];
  end
  assign wbyte = lane_bytes[lane];

  at_refresh_timer #(.CLK_KHZ(CLK_KHZ), .REFRESH_NS(REFRESH_NS)) u_rfsh (
    .clk (clk),
    .rst (rst),
    .tgl (refresh_tgl)
  );

  at_ctrl_port u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .latch_wr (ctrl_hit && io_wr),
    .wbyte    (wbyte),
    .nmi_load (rtc_index_wr),
    .refresh  (refresh_tgl),
    .t2       (t2_out),
    .latch    (latch),
    .nmi_en   (nmi_en),
    .rb_value (rb_value)
  );

  assign spk_gate = latch[0];
  assign spk_data = latch[1];

  assign rd_only = io_rd && !io_wr;
  always_comb begin
    rdata_n = 8'h00;
    if (rd_only) begin
      if (ctrl_hit)          rdata_n = rb_value;
      else if (sel_n == '0)  rdata_n = FLOAT_DATA;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel     <= '0;
      reg_idx <= '0;
      rdata   <= 8'h00;
    end else begin
      sel     <= sel_n;
      reg_idx <= idx_n;
      rdata   <= rdata_n;
    end
  end

  // R1: never more than one peripheral selected
  p_sel_onehot_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel));
  // R5: idle or conflicting strobes produce nothing
  p_idle_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    !(io_rd ^ io_wr) |=> (sel == '0) && (rdata == 8'h00));
  // R6: reads above the legacy page float high
  p_high_float_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_only && (io_dw_addr[IO_AW-1:8] != '0)) |=> (rdata == 8'hFF) && (sel == '0));
  // R9: upper two readback bits of the control port are zero
  p_ctrl_upper_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_only && ctrl_hit) |=> (rdata[7:6] == 2'b00) && (sel == '0));
endmodule

// File: tb/test_at_sysport_decoder.sv
module test_at_sysport_decoder;
  localparam int TOGGLE = 754;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:2] io_dw_addr = '0;
  logic [3:0]  io_be = '0;
  logic        io_rd = 1'b0;
  logic        io_wr = 1'b0;
  logic [31:0] io_wdata = '0;
  logic        t2_out = 1'b0;
  logic [9:0]  sel;
  logic [4:0]  reg_idx;
  logic [7:0]  rdata;
  logic        spk_gate, spk_data, nmi_en, refresh_tgl;

  int vectors = 0;
  int miscompares = 0;
  logic [3:0] latch_m = '0;
  logic       nmi_m = 1'b0;

  always #10 clk = ~clk;

  at_sysport_decoder i_at_sysport_decoder (
    .clk(clk), .rst(rst), .io_dw_addr(io_dw_addr), .io_be(io_be),
    .io_rd(io_rd), .io_wr(io_wr), .io_wdata(io_wdata), .t2_out(t2_out),
    .sel(sel), .reg_idx(reg_idx), .rdata(rdata), .spk_gate(spk_gate),
    .spk_data(spk_data), .nmi_en(nmi_en), .refresh_tgl(refresh_tgl)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] e_sel(input int b, input bit rd);
    logic [9:0] s = '0;
    if (b < 32) s[0] = 1'b1;
    else if (b < 64) s[1] = 1'b1;
    else if (b < 96) s[2] = 1'b1;
    else if (b == 96) s[3] = 1'b1;
    else if (b >= 100 && b < 104) begin
      if (rd) s[4] = 1'b1; else s[5] = 1'b1;
    end
    else if (b >= 112 && b < 128) s[6] = 1'b1;
    else if (b >= 128 && b < 160) s[7] = 1'b1;
    else if (b >= 160 && b < 192) s[8] = 1'b1;
    else if (b >= 192 && b < 224) s[9] = 1'b1;
    return s;
  endfunction

  function automatic logic [4:0] e_idx(input int b);
    if (b < 96) return 5'(b % 32);
    if (b >= 100 && b < 104) return 5'(b - 100);
    if (b >= 112 && b < 128) return 5'(b - 112);
    if (b >= 128 && b < 192) return 5'(b % 32);
    if (b >= 192 && b < 224) return 5'((b - 192) / 2);
    return 5'd0;
  endfunction

  // one access cycle; returns refresh value seen at the capturing edge
  task automatic acc(input logic [15:0] a, input logic [3:0] be, input logic rd,
                     input logic wr, input logic [31:0] wd, input logic t2v,
                     output logic refs);
    @(negedge clk);
    io_dw_addr = a[15:2]; io_be = be; io_rd = rd; io_wr = wr;
    io_wdata = wd; t2_out = t2v;
    refs = refresh_tgl;
    @(negedge clk);
    io_rd = 1'b0; io_wr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic r;
    logic [7:0] erd;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12: reset state
    chk("R12 sel", 32'(sel), 0);
    chk("R12 rdata", 32'(rdata), 0);
    chk("R12 latch/nmi/refresh", {29'd0, spk_gate | spk_data, nmi_en, refresh_tgl}, 0);

    // R1 R2 R3 R4 R6 R7: full sweep, read then write of every byte
    for (int b = 0; b < 256; b++) begin
      acc(16'(b), 4'(1 << (b % 4)), 1'b1, 1'b0, 32'd0, 1'b0, r);
      chk($sformatf("R1/R2/R3 sel rd byte %02h", b), 32'(sel), 32'(e_sel(b, 1'b1)));
      chk($sformatf("R4 idx rd byte %02h", b), 32'(reg_idx), 32'(e_idx(b)));
      if (b == 97) erd = {2'b00, 1'b0, r, latch_m};
      else if (e_sel(b, 1'b1) != 0) erd = 8'h00;
      else erd = 8'hFF;
      chk($sformatf("R6/R9 rdata byte %02h", b), 32'(rdata), 32'(erd));
      acc(16'(b), 4'(1 << (b % 4)), 1'b0, 1'b1, 32'd0, 1'b0, r);
      chk($sformatf("R3 sel wr byte %02h", b), 32'(sel), 32'(e_sel(b, 1'b0)));
      chk($sformatf("R4 idx wr byte %02h", b), 32'(reg_idx), 32'(e_idx(b)));
      chk($sformatf("R7 rdata wr byte %02h", b), 32'(rdata), 0);
    end

    // R5: byte enable and upper address corner cases
    acc(16'h0020, 4'b0011, 1'b1, 1'b0, 32'd0, 1'b0, r);
    chk("R5 two lanes sel", 32'(sel), 0);
    chk("R5 two lanes rdata", 32'(rdata), 32'hFF);
    acc(16'h0020, 4'b0000, 1'b1, 1'b0, 32'd0, 1'b0, r);
    chk("R5 no lane sel", 32'(sel), 0);
    acc(16'h0120, 4'b0001, 1'b1, 1'b0, 32'd0, 1'b0, r);
    chk("R5 upper addr sel", 32'(sel), 0);
    chk("R6 upper addr rdata", 32'(rdata), 32'hFF);
    acc(16'h0020, 4'b0001, 1'b1, 1'b1, 32'd0, 1'b0, r);
    chk("R5 both strobes sel", 32'(sel), 0);
    chk("R5 both strobes rdata", 32'(rdata), 0);
    acc(16'h8070, 4'b0001, 1'b0, 1'b1, 32'h80, 1'b0, r);
    chk("R5 upper addr no nmi", 32'(nmi_en), 0);

    // R8 R9: control port latch and readback
    acc(16'h0060, 4'b0010, 1'b0, 1'b1, 32'h0000FF00, 1'b0, r);
    latch_m = 4'hF;
    chk("R8 gate/data after FF", {30'd0, spk_data, spk_gate}, 3);
    acc(16'h0060, 4'b0010, 1'b1, 1'b0, 32'd0, 1'b0, r);
    chk("R9 readback t2=0", 32'(rdata), 32'({2'b00, 1'b0, r, latch_m}));
    acc(16'h0060, 4'b0010, 1'b0, 1'b1, 32'h0000A600, 1'b1, r);
    latch_m = 4'h6;
    chk("R8 gate/data after A6", {30'd0, spk_data, spk_gate}, 2);
    acc(16'h0060, 4'b0010, 1'b1, 1'b0, 32'd0, 1'b1, r);
    chk("R9 readback t2=1", 32'(rdata), 32'({2'b00, 1'b1, r, latch_m}));
    acc(16'h0060, 4'b0001, 1'b0, 1'b1, 32'h000000FF, 1'b0, r);
    chk("R8 lane0 write leaves latch", {30'd0, spk_data, spk_gate}, 2);

    // R11: NMI enable
    acc(16'h0070, 4'b0001, 1'b0, 1'b1, 32'h00000080, 1'b0, r);
    nmi_m = 1'b1;
    chk("R11 nmi set", 32'(nmi_en), 32'(nmi_m));
    acc(16'h0070, 4'b0010, 1'b0, 1'b1, 32'h00000000, 1'b0, r);
    chk("R11 other rtc byte", 32'(nmi_en), 32'(nmi_m));
    acc(16'h0070, 4'b0001, 1'b1, 1'b0, 32'h00000000, 1'b0, r);
    chk("R11 read keeps nmi", 32'(nmi_en), 32'(nmi_m));
    acc(16'h0070, 4'b0001, 1'b0, 1'b1, 32'h0000007F, 1'b0, r);
    nmi_m = 1'b0;
    chk("R11 nmi clear", 32'(nmi_en), 32'(nmi_m));

    // R10: refresh toggle period
    begin
      logic prev;
      int n;
      prev = refresh_tgl;
      while (refresh_tgl == prev) @(negedge clk);
      prev = refresh_tgl;
      n = 0;
      while (refresh_tgl == prev && n < 5000) begin
        @(negedge clk);
        n++;
      end
      chk("R10 toggle period", 32'(n), TOGGLE);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule